// File: doc/BRIEF.md
# Sync Header Error-Rate Monitor

This receive-path block judges link quality from the two-bit sync header that leads every 66-bit block. A header of 01 (data) or 10 (control) is legal; 00 and 11 can never be sent, so each one seen is counted as one error. The payload is never examined. Errors are tallied inside back-to-back windows of fixed length, measured in clock cycles. If a window collects the threshold number of errors, a level flag toward the MAC goes high. The flag drops only at the close of a complete window that stayed below the threshold.

When block lock is absent, the monitor has nothing meaningful to judge. It then holds its window timer and error tally at zero and keeps the flag high. When lock returns, the first window opens and the flag stays high until that window closes clean. The defaults give 16 errors per 19531 cycles, which is 125 µs at a 156.25 MHz block clock.

The control is a three-state machine. UNLOCKED holds everything cleared with the flag high. TRIPPED counts inside windows with the flag high. CLEAN counts inside windows with the flag low. Its transitions are:
- any state to UNLOCKED when lock is low;
- UNLOCKED to TRIPPED when lock is present;
- CLEAN to TRIPPED as soon as the running tally, including the current block, reaches the threshold;
- TRIPPED to CLEAN at the last cycle of a window whose tally, including that cycle's block, is below the threshold.

Top module: `sync_hdr_ber_monitor`

## Requirements
- R1: While `blk_valid` is high, a header of 2'b00 or 2'b11 counts as one error; 2'b01 and 2'b10 count as none.
- R2: A header presented while `blk_valid` is low has no effect on the tally.
- R3: In CLEAN, the flag goes high on the clock edge that samples the THRESHOLD-th error of the current window, even in the middle of the window.
- R4: A window spans WIN_CYCLES clock edges. The tally is zeroed at each window end, so errors never carry into the next window.
- R5: At a window end, the flag is low afterwards if fewer than THRESHOLD errors were counted in that window, and high otherwise. An error sampled on the window's last edge belongs to that window.
- R6: Once high, the flag stays high until a complete window closes with fewer than THRESHOLD errors.
- R7: On the edge that samples `blk_lock` low, the state becomes UNLOCKED: the flag is high and the timer and tally are held at zero. The first window opens on the edge after lock is seen again.
- R8: The error tally saturates at THRESHOLD and never wraps, so a window with more errors than the counter could hold still reports a high rate.
- R9: While `rst_n` is low, the monitor is in UNLOCKED with the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A header is present this cycle |
| blk_hdr | input | 2 | Sync header of the current 66-bit block |
| blk_lock | input | 1 | Block alignment achieved |
| hi_ber | output | 1 | High error-rate flag toward the MAC |

## Verification
The hardest case to reach is counter saturation. It needs a single window with more errors than the tally register could hold if it wrapped. The flag has to already be high at that moment, because only then does a wrapped, small tally wrongly clear it at the window end. The bench uses a short window (40 cycles) that is longer than twice the threshold, trips the flag in one window, and fills the next with 34 errors. It runs in lockstep with the window boundary, which it derives from the edge on which lock is first seen. That same alignment lets it place errors exactly on a window's final edge and straddle a boundary with 15 plus 5 errors.

// File: rtl/shbm_pkg.sv
package shbm_pkg;

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_TRIPPED  = 2'd1,
        ST_CLEAN    = 2'd2
    } mon_state_t;

    // A sync header with equal bits can never be legal.
    function automatic logic hdr_is_bad(input logic [1:0] hdr);
        return hdr[1] == hdr[0];
    endfunction

endpackage

// File: rtl/shbm_window_timer.sv
module shbm_window_timer #(
    parameter int unsigned WIN_CYCLES = 19531
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic win_end
);
    localparam int unsigned TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

    logic [TW-1:0] tick_q;

    assign win_end = run && (tick_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run || win_end) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assert_timer_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= LAST);

    assert_timer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> tick_q == '0);

endmodule

// File: rtl/shbm_err_counter.sv
module shbm_err_counter #(
    parameter int unsigned THRESHOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic win_end,
    input  logic err_now,
    output logic [$clog2(THRESHOLD+1)-1:0] tally_incl
);
    localparam int unsigned CW = $clog2(THRESHOLD + 1);
    localparam logic [CW-1:0] CAP = CW'(THRESHOLD);

    logic [CW-1:0] tally_q;

    // Running tally including the block sampled this cycle, held at the cap.
    always_comb begin
        if (err_now && (tally_q < CAP)) begin
            tally_incl = tally_q + 1'b1;
        end else begin
            tally_incl = tally_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else if (!run || win_end) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_incl;
        end
    end

    assert_tally_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tally_q <= CAP);

    assert_tally_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && win_end) |=> tally_q == '0);

endmodule

// File: rtl/sync_hdr_ber_monitor.sv
module sync_hdr_ber_monitor
    import shbm_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 19531,
    parameter int unsigned THRESHOLD  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_valid,
    input  logic [1:0] blk_hdr,
    input  logic       blk_lock,
    output logic       hi_ber
);
    localparam int unsigned CW = $clog2(THRESHOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESHOLD);

    mon_state_t state_q, state_d;
    logic          run;
    logic          win_end;
    logic          err_now;
    logic [CW-1:0] tally_incl;

    assign run     = blk_lock && (state_q != ST_UNLOCKED);
    assign err_now = blk_valid && hdr_is_bad(blk_hdr);

    shbm_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .win_end (win_end)
    );

    shbm_err_counter #(.THRESHOLD(THRESHOLD)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .win_end    (win_end),
        .err_now    (err_now),
        .tally_incl (tally_incl)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOCKED: if (blk_lock) state_d = ST_TRIPPED;
            ST_TRIPPED: begin
                if (!blk_lock)                           state_d = ST_UNLOCKED;
                else if (win_end && tally_incl < LIMIT)  state_d = ST_CLEAN;
            end
            ST_CLEAN: begin
                if (!blk_lock)                state_d = ST_UNLOCKED;
                else if (tally_incl >= LIMIT) state_d = ST_TRIPPED;
            end
            default: state_d = ST_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNLOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        hi_ber = (state_q != ST_CLEAN);
    end

    assert_lock_loss_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_lock |=> hi_ber);

    assert_clear_only_at_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_ber) |-> $past(win_end));

    assert_trip_on_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAN && blk_lock && tally_incl >= LIMIT) |=> hi_ber);

    assert_window_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_lock && win_end && tally_incl < LIMIT) |=> !hi_ber);

endmodule

// File: tb/sync_hdr_ber_monitor_tb.sv
`timescale 1ns/1ps
module sync_hdr_ber_monitor_tb;

    localparam int WIN = 40;
    localparam int THR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_valid = 1'b0;
    logic [1:0] blk_hdr = 2'b01;
    logic       blk_lock = 1'b0;
    logic       hi_ber;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    sync_hdr_ber_monitor #(.WIN_CYCLES(WIN), .THRESHOLD(THR)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .blk_hdr   (blk_hdr),
        .blk_lock  (blk_lock),
        .hi_ber    (hi_ber)
    );

    typedef struct packed {
        logic [7:0] nbad;
        logic [1:0] code;
        logic       at_end;
        logic       strobe;
        logic       exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  2'b00, 1'b0, 1'b1, 1'b0},  // R6 clean first window clears
        '{8'd15, 2'b00, 1'b1, 1'b1, 1'b0},  // R5 one below threshold
        '{8'd5,  2'b11, 1'b0, 1'b1, 1'b0},  // R4 straddle: no carry
        '{8'd16, 2'b11, 1'b1, 1'b1, 1'b1},  // R5 16th error on last edge
        '{8'd0,  2'b00, 1'b0, 1'b1, 1'b0},  // R6 clean window clears
        '{8'd16, 2'b00, 1'b0, 1'b0, 1'b0},  // R2 bad codes with strobe low
        '{8'd20, 2'b00, 1'b0, 1'b1, 1'b1},  // R1 code 00 trips
        '{8'd34, 2'b11, 1'b0, 1'b1, 1'b1},  // R8 beyond counter range
        '{8'd15, 2'b11, 1'b0, 1'b1, 1'b0},  // R6 clears below threshold
        '{8'd16, 2'b00, 1'b0, 1'b1, 1'b1},  // R1 exactly threshold
        '{8'd8,  2'b11, 1'b1, 1'b1, 1'b0}   // R5 clears again
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: hi_ber=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_good(input int i);
        blk_valid = 1'b1;
        blk_hdr   = i[0] ? 2'b01 : 2'b10;
    endtask

    // Caller is at a negedge at window start; returns at the negedge after the window's last edge.
    task automatic run_window(input int nbad, input logic [1:0] code,
                              input logic at_end, input logic strobe);
        for (int i = 0; i < WIN; i++) begin
            logic bad;
            bad = at_end ? (i >= WIN - nbad) : (i < nbad);
            if (bad) begin
                blk_valid = strobe;
                blk_hdr   = code;
            end else begin
                drive_good(i);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 flag in reset", hi_ber, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 flag while unlocked", hi_ber, 1'b1);

        blk_lock = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            run_window(int'(VECS[v].nbad), VECS[v].code, VECS[v].at_end, VECS[v].strobe);
            check($sformatf("table vector %0d", v), hi_ber, VECS[v].exp);
        end

        // R3: mid-window trip from the clean state
        for (int i = 0; i < WIN; i++) begin
            if (i < THR) begin
                blk_valid = 1'b1;
                blk_hdr   = 2'b00;
            end else begin
                drive_good(i);
            end
            @(negedge clk);
            if (i == THR - 2) check("R3 after 15 errors", hi_ber, 1'b0);
            if (i == THR - 1) check("R3 after 16th error", hi_ber, 1'b1);
            if (i == WIN - 2) check("R6 held before window end", hi_ber, 1'b1);
        end
        check("R5 tripped window stays high", hi_ber, 1'b1);
        run_window(0, 2'b00, 1'b0, 1'b1);
        check("R6 next clean window clears", hi_ber, 1'b0);

        // R7: loss of lock
        blk_lock  = 1'b0;
        blk_valid = 1'b1;
        blk_hdr   = 2'b11;
        @(negedge clk);
        check("R7 flag on lock loss", hi_ber, 1'b1);
        repeat (5) @(negedge clk);
        check("R7 flag held while unlocked", hi_ber, 1'b1);
        blk_lock = 1'b1;
        drive_good(0);
        @(negedge clk);
        for (int i = 0; i < WIN - 1; i++) begin
            drive_good(i);
            @(negedge clk);
        end
        check("R6 high one edge before first window ends", hi_ber, 1'b1);
        drive_good(1);
        @(negedge clk);
        check("R7 first relocked window clears", hi_ber, 1'b0);

        // R9: reset while clean
        rst_n = 1'b0;
        #1;
        check("R9 async reset raises flag", hi_ber, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule